// File: doc/BRIEF.md
# Companding Successive-Approximation Conversion Sequencer

This block is the digital half of a frame-rate analog-to-digital converter. Each 8 kHz frame strobe starts one conversion. The block first autozeroes the comparator. It then makes eight comparator decisions: the polarity first, then seven magnitude decisions. The trial magnitude is presented to a segmented DAC as a 3-bit chord, which selects a binary-weighted capacitor group, and a 4-bit step, which selects a tap on a linear resistor ladder. The analog DAC, the reference and the comparator sit outside the block and answer through a single comparator bit.

By default the magnitude follows the Mu-Law segment curve, and the byte is sent out complemented on a valid/ready stream. A linear-mode pin makes the DAC uniform and the byte plain sign-magnitude. A two-bit I/O mode field can instead point the conversion at an auxiliary monitor input. That conversion is always linear, and its result goes into a readable monitor register rather than onto the stream.

The output stream holds one word. The word stays on `pcm_data` with `pcm_valid` high until a cycle in which `pcm_ready` is high. While a word is waiting and `pcm_ready` is low, a frame strobe is refused, so no word is ever overwritten.

Top module: `companding_sar_adc`

## Requirements
- R1: After reset `pcm_valid`, `conv_done`, `az_en` and `aux_sel` are low and `mon_value` is 0x00.
- R2: An accepted strobe raises `az_en` for exactly one cycle, directly before the polarity trial.
- R3: The polarity trial comes first. During it `trial_sign` is high, chord and step are 0 and `dac_neg` is low. Every trial, polarity or magnitude, is held for two cycles (one settle and one sample). The first magnitude trial is chord 4, step 0 (code 100 0000). The magnitude bits are then decided MSB first.
- R4: Companded mode (`lin_mode` 0). The comparator answers 1 when the input magnitude is at least ((16+step) << (chord+1)) - 33. The output byte is the bitwise complement of {negative, chord[2:0], step[3:0]}, where negative is 1 when the polarity trial answered 0. Positive full scale gives 0x80, zero gives 0xFF and negative full scale gives 0x00.
- R5: Linear mode (`lin_mode` 1). `dac_linear` is high during the magnitude trials and the threshold is code*64. The byte is {negative, magnitude[6:0]}, not complemented, with magnitude = min(|x|/64, 127).
- R6: When `io_mode` is 2'b10, `aux_sel` is high for the conversion and the conversion is linear. The result {sign, magnitude} goes to `mon_value`, whose bit 7 carries no meaning. `pcm_valid` is not raised. Conversions in other modes leave `mon_value` unchanged.
- R7: `conv_done` is a one-cycle pulse 18 clocks after the edge that accepts the strobe. A stream word becomes valid on the same edge.
- R8: A strobe that arrives while a conversion is running is ignored.
- R9: While `pcm_valid` is high and `pcm_ready` is low, `pcm_valid` and `pcm_data` hold. The edge with `pcm_ready` high clears `pcm_valid`, and a strobe arriving while the word waits is refused.
- R10: `lin_mode` and `io_mode` are captured when the strobe is accepted. Changing them mid-conversion has no effect.
- R11: During the magnitude trials `dac_neg` equals the polarity decided for this conversion and does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_strb | input | 1 | Frame strobe; starts a conversion when accepted |
| lin_mode | input | 1 | 1 selects linear result, 0 Mu-Law companded |
| io_mode | input | 2 | 2'b10 selects the auxiliary monitor input |
| cmp_in | input | 1 | Comparator decision for the current trial |
| az_en | output | 1 | Comparator autozero enable |
| aux_sel | output | 1 | Routes the auxiliary input to the comparator |
| trial_sign | output | 1 | Polarity trial in progress |
| dac_neg | output | 1 | DAC trial polarity (1 = negative) |
| dac_linear | output | 1 | DAC interprets chord/step as one uniform 7-bit code |
| dac_chord | output | 3 | Trial chord code |
| dac_step | output | 4 | Trial step code |
| conv_done | output | 1 | One-cycle end-of-conversion pulse |
| pcm_data | output | 8 | Output stream word |
| pcm_valid | output | 1 | Stream word valid |
| pcm_ready | input | 1 | Stream consumer ready |
| mon_value | output | 8 | Last auxiliary monitor result |

## Verification
Companded conversions are run at zero, at small and mid levels of both polarities, and beyond full scale in each direction. These separate a wrong segment threshold, a wrong step extraction, a missing complement and a wrong polarity decision. The same inputs in linear mode expose a DAC or result path stuck in companded form. The saturation inputs expose missing clipping. Auxiliary conversions are run with a signal input whose value differs from the auxiliary value, which shows whether the result comes from the right source and lands in the right register. Strobes during a conversion and during back-pressure, together with mode flips part-way through a conversion, show whether the strobe gating and the mode capture work.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_AZERO,
    ST_SETTLE,
    ST_SAMPLE,
    ST_DONE
  } sar_state_t;

  typedef struct packed {
    logic lin;
    logic mon;
  } conv_mode_t;
endpackage

// File: rtl/sar_seq.sv
module sar_seq
  import sar_adc_pkg::*;
#(
  parameter int NBITS      = 8,
  parameter int SETTLE_CYC = 1,
  localparam int IDX_W     = $clog2(NBITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output sar_state_t       state,
  output logic [IDX_W-1:0] bit_idx
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC - 1);
  localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(NBITS - 1);

  logic [CNT_W-1:0] settle_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      bit_idx    <= '0;
      settle_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) state <= ST_AZERO;
        end
        ST_AZERO: begin
          state      <= ST_SETTLE;
          bit_idx    <= IDX_TOP;
          settle_cnt <= CNT_LOAD;
        end
        ST_SETTLE: begin
          if (settle_cnt == '0) state <= ST_SAMPLE;
          else settle_cnt <= settle_cnt - 1'b1;
        end
        ST_SAMPLE: begin
          if (bit_idx == '0) begin
            state <= ST_DONE;
          end else begin
            bit_idx    <= bit_idx - 1'b1;
            settle_cnt <= CNT_LOAD;
            state      <= ST_SETTLE;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
  parameter int MAG_W = 7,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             sample_now,
  input  logic             sign_phase,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp,
  output logic             neg,
  output logic [MAG_W-1:0] mag
);
  logic [MAG_W-1:0] mag_nxt;

  // Resolve the bit under test and raise the next lower one as the new trial.
  always_comb begin
    mag_nxt = mag;
    if (sign_phase) begin
      mag_nxt[MAG_W-1] = 1'b1;
    end else begin
      for (int k = 0; k < MAG_W; k++) begin
        if (IDX_W'(k) == bit_idx)     mag_nxt[k] = cmp;
        if (IDX_W'(k + 1) == bit_idx) mag_nxt[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg <= 1'b0;
      mag <= '0;
    end else if (clear) begin
      neg <= 1'b0;
      mag <= '0;
    end else if (sample_now) begin
      if (sign_phase) neg <= ~cmp;
      mag <= mag_nxt;
    end
  end
endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int MAG_W     = 7,
  parameter bit MU_INVERT = 1'b1,
  localparam int W        = MAG_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             finish,
  input  logic             lin,
  input  logic             mon,
  input  logic             neg,
  input  logic [MAG_W-1:0] mag,
  input  logic             pcm_ready,
  output logic [W-1:0]     pcm_data,
  output logic             pcm_valid,
  output logic             conv_done,
  output logic [W-1:0]     mon_value,
  output logic             slot_free
);
  logic [W-1:0] raw_word;
  logic [W-1:0] comp_word;
  logic [W-1:0] out_word;

  assign raw_word = {neg, mag};

  generate
    if (MU_INVERT) begin : g_inv
      assign comp_word = ~raw_word;
    end else begin : g_plain
      assign comp_word = raw_word;
    end
  endgenerate

  assign out_word  = lin ? raw_word : comp_word;
  assign slot_free = !pcm_valid || pcm_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcm_data  <= '0;
      pcm_valid <= 1'b0;
      conv_done <= 1'b0;
      mon_value <= '0;
    end else begin
      conv_done <= finish;
      if (finish && !mon) begin
        pcm_data  <= out_word;
        pcm_valid <= 1'b1;
      end else if (pcm_valid && pcm_ready) begin
        pcm_valid <= 1'b0;
      end
      if (finish && mon) mon_value <= raw_word;
    end
  end
endmodule

// File: rtl/companding_sar_adc.sv
module companding_sar_adc
  import sar_adc_pkg::*;
#(
  parameter int          CHORD_W    = 3,
  parameter int          STEP_W     = 4,
  parameter int          SETTLE_CYC = 1,
  parameter logic [1:0]  MON_CODE   = 2'b10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_strb,
  input  logic               lin_mode,
  input  logic [1:0]         io_mode,
  input  logic               cmp_in,
  output logic               az_en,
  output logic               aux_sel,
  output logic               trial_sign,
  output logic               dac_neg,
  output logic               dac_linear,
  output logic [CHORD_W-1:0] dac_chord,
  output logic [STEP_W-1:0]  dac_step,
  output logic               conv_done,
  output logic [CHORD_W+STEP_W:0] pcm_data,
  output logic               pcm_valid,
  input  logic               pcm_ready,
  output logic [CHORD_W+STEP_W:0] mon_value
);
  localparam int MAG_W = CHORD_W + STEP_W;
  localparam int NBITS = MAG_W + 1;
  localparam int IDX_W = $clog2(NBITS);
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(NBITS - 1);

  sar_state_t       state;
  logic [IDX_W-1:0] bit_idx;
  logic             start;
  logic             busy;
  logic             trial_act;
  logic             sign_phase;
  logic             slot_free;
  logic             neg;
  logic [MAG_W-1:0] mag;
  conv_mode_t       mode_q;

  assign busy       = (state != ST_IDLE);
  assign trial_act  = (state == ST_SETTLE) || (state == ST_SAMPLE);
  assign sign_phase = trial_act && (bit_idx == IDX_TOP);
  assign start      = frame_strb && !busy && slot_free;

  // Mode is captured once per conversion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (start) begin
      mode_q.mon <= (io_mode == MON_CODE);
      mode_q.lin <= lin_mode;
    end
  end

  sar_seq #(
    .NBITS      (NBITS),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .state   (state),
    .bit_idx (bit_idx)
  );

  sar_trial #(
    .MAG_W (MAG_W),
    .IDX_W (IDX_W)
  ) u_trial (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (state == ST_AZERO),
    .sample_now (state == ST_SAMPLE),
    .sign_phase (sign_phase),
    .bit_idx    (bit_idx),
    .cmp        (cmp_in),
    .neg        (neg),
    .mag        (mag)
  );

  sar_result #(
    .MAG_W     (MAG_W),
    .MU_INVERT (1'b1)
  ) u_result (
    .clk       (clk),
    .rst_n     (rst_n),
    .finish    (state == ST_DONE),
    .lin       (mode_q.lin || mode_q.mon),
    .mon       (mode_q.mon),
    .neg       (neg),
    .mag       (mag),
    .pcm_ready (pcm_ready),
    .pcm_data  (pcm_data),
    .pcm_valid (pcm_valid),
    .conv_done (conv_done),
    .mon_value (mon_value),
    .slot_free (slot_free)
  );

  assign az_en      = (state == ST_AZERO);
  assign aux_sel    = busy && mode_q.mon;
  assign trial_sign = sign_phase;
  assign dac_neg    = neg && trial_act && !sign_phase;
  assign dac_linear = trial_act && !sign_phase && (mode_q.lin || mode_q.mon);
  assign dac_chord  = trial_act ? mag[MAG_W-1 -: CHORD_W] : '0;
  assign dac_step   = trial_act ? mag[STEP_W-1:0] : '0;
endmodule

// File: rtl/sar_adc_checker.sv
module sar_adc_checker #(
  parameter int CW = 3,
  parameter int SW = 4,
  parameter int W  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          az_en,
  input logic          trial_sign,
  input logic          trial_act,
  input logic [CW-1:0] dac_chord,
  input logic [SW-1:0] dac_step,
  input logic          dac_neg,
  input logic          aux_sel,
  input logic          conv_done,
  input logic          pcm_valid,
  input logic          pcm_ready,
  input logic [W-1:0]  pcm_data
);
  assert_az_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    az_en |=> !az_en);

  assert_az_then_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    az_en |=> trial_sign);

  assert_sign_zero_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    trial_sign |-> (dac_chord == '0 && dac_step == '0 && !dac_neg));

  assert_sign_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trial_sign) |=> trial_sign);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  assert_valid_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_valid) |-> conv_done);

  assert_hold_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_valid && !pcm_ready) |=> (pcm_valid && $stable(pcm_data)));

  assert_mon_no_stream_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pcm_valid) |-> !$past(aux_sel));

  assert_neg_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_act && !trial_sign && $past(trial_act && !trial_sign)) |-> $stable(dac_neg));
endmodule

bind companding_sar_adc sar_adc_checker u_sar_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .az_en      (az_en),
  .trial_sign (trial_sign),
  .trial_act  (trial_act),
  .dac_chord  (dac_chord),
  .dac_step   (dac_step),
  .dac_neg    (dac_neg),
  .aux_sel    (aux_sel),
  .conv_done  (conv_done),
  .pcm_valid  (pcm_valid),
  .pcm_ready  (pcm_ready),
  .pcm_data   (pcm_data)
);

// File: tb/companding_sar_adc_bench.sv
module companding_sar_adc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYC     = 20000;
  localparam int LAT_EDGES  = 19;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_strb = 1'b0;
  logic       lin_mode = 1'b0;
  logic [1:0] io_mode = 2'b00;
  logic       cmp_in;
  logic       pcm_ready = 1'b1;
  logic       az_en, aux_sel, trial_sign, dac_neg, dac_linear;
  logic [2:0] dac_chord;
  logic [3:0] dac_step;
  logic       conv_done, pcm_valid;
  logic [7:0] pcm_data, mon_value;

  int sig_val = 0;
  int aux_val = 0;
  int src, lvl, mag_in;

  int checks = 0;
  int errors = 0;
  int edges  = 0;

  int         az_cnt = 0, sign_cnt = 0, aux_cnt = 0;
  logic [6:0] first_code = '0;
  logic       first_neg = 1'b0, first_lin = 1'b0;
  logic       prev_sign = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  companding_sar_adc u_companding_sar_adc (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_strb (frame_strb),
    .lin_mode   (lin_mode),
    .io_mode    (io_mode),
    .cmp_in     (cmp_in),
    .az_en      (az_en),
    .aux_sel    (aux_sel),
    .trial_sign (trial_sign),
    .dac_neg    (dac_neg),
    .dac_linear (dac_linear),
    .dac_chord  (dac_chord),
    .dac_step   (dac_step),
    .conv_done  (conv_done),
    .pcm_data   (pcm_data),
    .pcm_valid  (pcm_valid),
    .pcm_ready  (pcm_ready),
    .mon_value  (mon_value)
  );

  // Ideal analog model: segmented or uniform DAC plus threshold comparator.
  always_comb begin
    src = aux_sel ? aux_val : sig_val;
    if (dac_linear) lvl = int'({dac_chord, dac_step}) * 64;
    else            lvl = ((16 + int'(dac_step)) << (int'(dac_chord) + 1)) - 33;
    mag_in = dac_neg ? -src : src;
    cmp_in = trial_sign ? (src >= 0) : (mag_in >= lvl);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (az_en)      az_cnt++;
      if (trial_sign) sign_cnt++;
      if (aux_sel)    aux_cnt++;
      if (prev_sign && !trial_sign) begin
        first_code = {dac_chord, dac_step};
        first_neg  = dac_neg;
        first_lin  = dac_linear;
      end
      prev_sign = trial_sign;
    end
  end

  function automatic logic [7:0] exp_mu(int x);
    int a, b, top, seg, stp;
    a = (x < 0) ? -x : x;
    if (a > 8158) a = 8158;
    b = a + 33;
    top = 5;
    for (int k = 5; k <= 12; k++) if (((b >> k) & 1) == 1) top = k;
    seg = top - 5;
    stp = (b >> (seg + 1)) & 15;
    return ~{(x < 0), 3'(seg), 4'(stp)};
  endfunction

  function automatic logic [7:0] exp_lin(int x);
    int a;
    a = ((x < 0) ? -x : x) >> 6;
    if (a > 127) a = 127;
    return {(x < 0), 7'(a)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    edges++;
  endtask

  task automatic start_conv(input int sig, input int aux, input bit lin, input logic [1:0] io);
    @(negedge clk);
    sig_val = sig; aux_val = aux; lin_mode = lin; io_mode = io;
    az_cnt = 0; sign_cnt = 0; aux_cnt = 0;
    first_code = '0; first_neg = 1'b0; first_lin = 1'b0;
    frame_strb = 1'b1;
    @(negedge clk);
    frame_strb = 1'b0;
    edges = 1;
  endtask

  task automatic wait_done(output logic [7:0] d, output bit v, output bit dn);
    dn = 1'b0; d = '0; v = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (conv_done) begin
        dn = 1'b1; d = pcm_data; v = pcm_valid;
        break;
      end
      tick();
    end
  endtask

  task automatic t_reset();
    check(!pcm_valid && !conv_done && !az_en && !aux_sel, "R1 reset controls",
          {pcm_valid, conv_done, az_en, aux_sel}, 0);
    check(mon_value == 8'h00, "R1 reset monitor", mon_value, 0);
  endtask

  task automatic t_mulaw();
    int vals [6] = '{9000, 0, -9000, 100, -1000, 5000};
    logic [7:0] d; bit v, dn;
    foreach (vals[i]) begin
      start_conv(vals[i], 0, 1'b0, 2'b00);
      wait_done(d, v, dn);
      check(dn && v, "R7 mu conversion completes", {dn, v}, 3);
      check(d == exp_mu(vals[i]), "R4 mu-law word", d, exp_mu(vals[i]));
      check(edges == LAT_EDGES, "R7 latency", edges, LAT_EDGES);
    end
  endtask

  task automatic t_sequence();
    logic [7:0] d; bit v, dn;
    start_conv(-700, 0, 1'b0, 2'b00);
    wait_done(d, v, dn);
    check(az_cnt == 1, "R2 autozero cycles", az_cnt, 1);
    check(sign_cnt == 2, "R3 polarity trial cycles", sign_cnt, 2);
    check(first_code == 7'b1000000, "R3 first magnitude trial", first_code, 7'h40);
    check(first_neg == 1'b1, "R11 negative polarity to DAC", first_neg, 1);
    check(first_lin == 1'b0, "R4 companded DAC", first_lin, 0);
    check(d == exp_mu(-700), "R4 mu-law negative", d, exp_mu(-700));
  endtask

  task automatic t_linear();
    int vals [4] = '{1000, -3000, 9000, 0};
    logic [7:0] d; bit v, dn;
    foreach (vals[i]) begin
      start_conv(vals[i], 0, 1'b1, 2'b00);
      wait_done(d, v, dn);
      check(dn && v, "R5 linear completes", {dn, v}, 3);
      check(d == exp_lin(vals[i]), "R5 linear word", d, exp_lin(vals[i]));
      check(first_lin == 1'b1, "R5 uniform DAC", first_lin, 1);
    end
  endtask

  task automatic t_monitor();
    logic [7:0] d; bit v, dn;
    start_conv(-5000, 4000, 1'b0, 2'b10);
    wait_done(d, v, dn);
    check(dn, "R6 monitor completes", dn, 1);
    check(!v, "R6 no stream word", v, 0);
    check(mon_value[6:0] == 7'd62, "R6 monitor magnitude", mon_value[6:0], 62);
    check(aux_cnt > 0 && first_lin, "R6 aux routed linear", {aux_cnt > 0, first_lin}, 3);
    start_conv(300, 1000, 1'b0, 2'b01);
    wait_done(d, v, dn);
    check(v && d == exp_mu(300), "R6 other io mode uses signal", d, exp_mu(300));
    check(mon_value[6:0] == 7'd62, "R6 monitor unchanged", mon_value[6:0], 62);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d; bit v, dn;
    int extra;
    start_conv(2000, 0, 1'b0, 2'b00);
    repeat (5) tick();
    frame_strb = 1'b1; tick(); frame_strb = 1'b0;
    wait_done(d, v, dn);
    check(edges == LAT_EDGES, "R8 strobe mid-conversion ignored", edges, LAT_EDGES);
    check(d == exp_mu(2000), "R8 word intact", d, exp_mu(2000));
    az_cnt = 0; extra = 0;
    repeat (25) begin tick(); if (conv_done) extra++; end
    check(az_cnt == 0 && extra == 0, "R8 no second conversion", az_cnt + extra, 0);
  endtask

  task automatic t_backpressure();
    logic [7:0] d; bit v, dn;
    bit held;
    pcm_ready = 1'b0;
    start_conv(100, 0, 1'b0, 2'b00);
    wait_done(d, v, dn);
    check(v && d == 8'hDF, "R9 word presented", d, 8'hDF);
    az_cnt = 0; held = 1'b1;
    frame_strb = 1'b1; tick(); frame_strb = 1'b0;
    repeat (20) begin
      tick();
      if (!pcm_valid || pcm_data != d) held = 1'b0;
    end
    check(held, "R9 word held under back-pressure", held, 1);
    check(az_cnt == 0, "R9 strobe refused while word waits", az_cnt, 0);
    pcm_ready = 1'b1;
    tick();
    check(!pcm_valid, "R9 handshake clears valid", pcm_valid, 0);
  endtask

  task automatic t_mode_snapshot();
    logic [7:0] d; bit v, dn;
    start_conv(1000, 3000, 1'b0, 2'b00);
    repeat (3) tick();
    lin_mode = 1'b1; io_mode = 2'b10;
    wait_done(d, v, dn);
    check(v && d == exp_mu(1000), "R10 mode changes ignored", d, exp_mu(1000));
    check(aux_cnt == 0, "R10 aux not selected", aux_cnt, 0);
    lin_mode = 1'b0; io_mode = 2'b00;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: cycles %0d expected below %0d", WD_CYC, WD_CYC);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mulaw();
    t_sequence();
    t_linear();
    t_monitor();
    t_busy_ignore();
    t_backpressure();
    t_mode_snapshot();
    summary();
    $finish;
  end
endmodule